// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block walks a small programmable table of time-slot entries on a time-division multiplexed serial line and produces the per-slot control for that line. A receive table runs on the receive bit clock and a transmit table runs on the transmit bit clock. Each table restarts at entry 0 when its sync input pulses. It processes entries in order until it finishes the entry marked as final, then idles until the next sync.

For every slot the block does four things. It sets four strobe outputs that belong to that table. It forwards received line bits to the channel named by the entry. It drives the transmit bit presented by the channel controllers onto the line. Each entry may also swap the two line pins for its own duration, so that the block receives from the line-transmit pin and drives the line-receive pin. A channel number of zero turns off both capture and drive for a slot. This is how one direction is silenced while the pins are swapped.

The tables are loaded through a plain write port per table, and writes are accepted only while that table is idle.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, all strobes are low, both line output enables are low, `rx_ch_valid` and `tx_ch_take` are low, and both tables are idle.
- R2: An entry is a 16-bit word. Bit 15 is the final flag and bit 14 is byte mode. Bits 13:10 are the count, bits 9:7 the channel, bit 5 the swap flag and bits 3:0 the four strobe levels. A slot lasts count+1 bit clocks, or (count+1)×8 bit clocks when byte mode is 1.
- R3: A sync pulse sampled on a table's clock edge makes entry 0 current from the next bit period on. This holds even when it arrives in the middle of a table pass.
- R4: After the bit period that ends the entry with the final flag set, the table idles. While idle, its strobes are low, no channel bit is forwarded or taken, and its line outputs are disabled. This lasts until the next sync.
- R5: Receive capture is taken from `line_rx_in` when the current receive entry has swap=0, and from `line_tx_in` when it has swap=1. The captured bit appears on `rx_ch_bit` one receive clock after the bit period in which it was sampled.
- R6: A transmit slot with a nonzero channel drives `tx_ch_bit` on `line_tx_out` with `line_tx_oe` high when swap=0. When swap=1 it drives it on `line_rx_out` with `line_rx_oe` high. The two enables are never high together.
- R7: An entry with channel 0 neither captures (`rx_ch_valid` low) nor drives (both enables low, `tx_ch_take` low). Otherwise the entry's channel number appears on `rx_ch_id` or `tx_ch_id` alongside the valid or take flag.
- R8: `strb[3:0]` follow the receive entry's strobe bits and change only on `clk_rx`. `strb[7:4]` follow the transmit entry's strobe bits and change only on `clk_tx`. Each keeps its level for the whole slot, and any number of strobes may be high at once.
- R9: A strobe set in two consecutive entries stays high across the boundary between them, with no low cycle.
- R10: A strobe output is high only while its bit of `strb_en` is 1. Otherwise it is held low.
- R11: Entry bits 6 and 4 are reserved and have no effect on any output.
- R12: A table write is accepted only while that table is idle. A write issued during a pass leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive bit clock |
| clk_tx | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| rx_sync | input | 1 | Receive frame start pulse |
| tx_sync | input | 1 | Transmit frame start pulse |
| rx_wr_en | input | 1 | Receive table write strobe |
| rx_wr_addr | input | 4 | Receive table write index |
| rx_wr_data | input | 16 | Receive table entry |
| tx_wr_en | input | 1 | Transmit table write strobe |
| tx_wr_addr | input | 4 | Transmit table write index |
| tx_wr_data | input | 16 | Transmit table entry |
| strb_en | input | 8 | Per-strobe dedicated-pin enable |
| line_rx_in | input | 1 | Level on the line-receive pin |
| line_tx_in | input | 1 | Level on the line-transmit pin |
| tx_ch_bit | input | 1 | Transmit bit from the channel side |
| line_tx_out | output | 1 | Data for the line-transmit pin |
| line_tx_oe | output | 1 | Output enable of the line-transmit pin |
| line_rx_out | output | 1 | Data for the line-receive pin when swapped |
| line_rx_oe | output | 1 | Output enable of the line-receive pin |
| rx_ch_valid | output | 1 | A received bit is present for a channel |
| rx_ch_id | output | 3 | Channel of the received bit |
| rx_ch_bit | output | 1 | Received bit |
| tx_ch_take | output | 1 | `tx_ch_bit` was launched on the line |
| tx_ch_id | output | 3 | Channel whose bit was launched |
| strb | output | 8 | Strobes; [3:0] receive side, [7:4] transmit side |

## Verification
Every cycle, the assertions check the following. A sync restarts the table at entry 0. A final entry stops the stepper and an idle table stays idle. A slot holds its index and its strobe levels from start to end. No strobe is high while its enable is low. The two line enables never overlap, and a valid capture never names channel 0. Some behaviour can only be shown by the bench's scenarios: the exact slot lengths in bit and byte mode, which pin a swapped slot samples or drives, the absence of a low cycle between adjacent strobe entries, the restart in mid-pass, reserved bits having no effect, and writes during a pass being dropped. For these, the bench compares against its own reference model on every edge of both clocks.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

  localparam int CNT_W   = 4;
  localparam int CH_W    = 3;
  localparam int STB_W   = 4;
  localparam int LEN_W   = CNT_W + 3;   // byte mode multiplies by eight
  localparam int ENTRY_W = 16;

  // Field positions are fixed: bit 6 and bit 4 are reserved (R11)
  typedef struct packed {
    logic             last;
    logic             byte_mode;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  chan;
    logic             rsv_a;
    logic             swap;
    logic             rsv_b;
    logic [STB_W-1:0] strb;
  } slot_entry_t;

  // Index of the final bit period of a slot (R2)
  function automatic logic [LEN_W-1:0] slot_last_pos(slot_entry_t e);
    if (e.byte_mode) slot_last_pos = {e.cnt, 3'b111};
    else             slot_last_pos = {3'b000, e.cnt};
  endfunction

endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_route_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  slot_entry_t   wdata,
  input  logic [AW-1:0] raddr_a,
  output slot_entry_t   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output slot_entry_t   rdata_b
);

  // Small table: one write port, two asynchronous reads -> distributed RAM
  slot_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tdm_route_step.sv
module tdm_route_step
  import tdm_route_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             wr_req,
  output logic             wr_ok,
  input  slot_entry_t      cur_e,
  input  slot_entry_t      nxt_e,
  input  logic [STB_W-1:0] strb_en,
  output logic             act_q,
  output logic [AW-1:0]    idx_q,
  output logic             nxt_act,
  output logic [AW-1:0]    nxt_idx,
  output logic [STB_W-1:0] strb_q
);

  logic [LEN_W-1:0] pos_q, nxt_pos;
  logic             slot_end;

  assign slot_end = (pos_q == slot_last_pos(cur_e));
  assign wr_ok    = wr_req && !act_q;   // R12

  // Fields the stepper does not look at; reserved bits are never decoded (R11)
  logic unused_fields;
  assign unused_fields = ^{cur_e.chan, cur_e.rsv_a, cur_e.swap, cur_e.rsv_b, cur_e.strb,
                           nxt_e.last, nxt_e.byte_mode, nxt_e.cnt, nxt_e.chan,
                           nxt_e.rsv_a, nxt_e.swap, nxt_e.rsv_b};

  always_comb begin
    nxt_act = act_q;
    nxt_idx = idx_q;
    nxt_pos = pos_q;
    if (sync) begin
      nxt_act = 1'b1;
      nxt_idx = '0;
      nxt_pos = '0;
    end else if (act_q) begin
      if (slot_end) begin
        nxt_pos = '0;
        if (cur_e.last) nxt_act = 1'b0;
        else if (idx_q == AW'(DEPTH - 1)) nxt_idx = '0;
        else nxt_idx = idx_q + 1'b1;
      end else begin
        nxt_pos = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      pos_q  <= '0;
      strb_q <= '0;
    end else begin
      act_q  <= nxt_act;
      idx_q  <= nxt_idx;
      pos_q  <= nxt_pos;
      // Level chosen from the entry of the coming period: no gap between entries
      strb_q <= nxt_act ? (nxt_e.strb & strb_en) : '0;
    end
  end

  // R3
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sync |=> (act_q && idx_q == '0 && pos_q == '0));

  // R4
  last_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !sync && slot_end && cur_e.last) |=> !act_q);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !sync) |=> (!act_q && strb_q == '0));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !sync && !slot_end) |=> (act_q && $stable(idx_q)));

  // R8
  strb_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !sync && !slot_end && $stable(strb_en)) |=> $stable(strb_q));

  // R10
  strb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((strb_q & ~$past(strb_en)) == '0));

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_route_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk_rx,
  input  logic               clk_tx,
  input  logic               rst,
  input  logic               rx_sync,
  input  logic               tx_sync,
  input  logic               rx_wr_en,
  input  logic [AW-1:0]      rx_wr_addr,
  input  logic [ENTRY_W-1:0] rx_wr_data,
  input  logic               tx_wr_en,
  input  logic [AW-1:0]      tx_wr_addr,
  input  logic [ENTRY_W-1:0] tx_wr_data,
  input  logic [2*STB_W-1:0] strb_en,
  input  logic               line_rx_in,
  input  logic               line_tx_in,
  input  logic               tx_ch_bit,
  output logic               line_tx_out,
  output logic               line_tx_oe,
  output logic               line_rx_out,
  output logic               line_rx_oe,
  output logic               rx_ch_valid,
  output logic [CH_W-1:0]    rx_ch_id,
  output logic               rx_ch_bit,
  output logic               tx_ch_take,
  output logic [CH_W-1:0]    tx_ch_id,
  output logic [2*STB_W-1:0] strb
);

  localparam int NLANE = 2;
  localparam int RXL   = 0;
  localparam int TXL   = 1;

  logic             lane_clk  [NLANE];
  logic             lane_sync [NLANE];
  logic             lane_wreq [NLANE];
  logic             lane_wok  [NLANE];
  logic [AW-1:0]    lane_wa   [NLANE];
  slot_entry_t      lane_wd   [NLANE];
  logic [STB_W-1:0] lane_en   [NLANE];
  slot_entry_t      lane_cur  [NLANE];
  slot_entry_t      lane_nxt  [NLANE];
  logic             lane_act  [NLANE];
  logic [AW-1:0]    lane_idx  [NLANE];
  logic             lane_nact [NLANE];
  logic [AW-1:0]    lane_nidx [NLANE];
  logic [STB_W-1:0] lane_strb [NLANE];

  assign lane_clk[RXL]  = clk_rx;
  assign lane_clk[TXL]  = clk_tx;
  assign lane_sync[RXL] = rx_sync;
  assign lane_sync[TXL] = tx_sync;
  assign lane_wreq[RXL] = rx_wr_en;
  assign lane_wreq[TXL] = tx_wr_en;
  assign lane_wa[RXL]   = rx_wr_addr;
  assign lane_wa[TXL]   = tx_wr_addr;
  assign lane_wd[RXL]   = slot_entry_t'(rx_wr_data);
  assign lane_wd[TXL]   = slot_entry_t'(tx_wr_data);
  assign lane_en[RXL]   = strb_en[STB_W-1:0];
  assign lane_en[TXL]   = strb_en[2*STB_W-1:STB_W];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    tdm_route_table #(.DEPTH(DEPTH)) u_tbl (
      .clk     (lane_clk[g]),
      .we      (lane_wok[g]),
      .waddr   (lane_wa[g]),
      .wdata   (lane_wd[g]),
      .raddr_a (lane_idx[g]),
      .rdata_a (lane_cur[g]),
      .raddr_b (lane_nidx[g]),
      .rdata_b (lane_nxt[g])
    );

    tdm_route_step #(.DEPTH(DEPTH)) u_step (
      .clk     (lane_clk[g]),
      .rst     (rst),
      .sync    (lane_sync[g]),
      .wr_req  (lane_wreq[g]),
      .wr_ok   (lane_wok[g]),
      .cur_e   (lane_cur[g]),
      .nxt_e   (lane_nxt[g]),
      .strb_en (lane_en[g]),
      .act_q   (lane_act[g]),
      .idx_q   (lane_idx[g]),
      .nxt_act (lane_nact[g]),
      .nxt_idx (lane_nidx[g]),
      .strb_q  (lane_strb[g])
    );
  end

  assign strb = {lane_strb[TXL], lane_strb[RXL]};

  // Receive capture: sample the pin chosen by the entry of the period now ending
  logic rx_take;
  assign rx_take = lane_act[RXL] && (lane_cur[RXL].chan != '0);

  always_ff @(posedge clk_rx) begin
    if (rst) begin
      rx_ch_valid <= 1'b0;
      rx_ch_id    <= '0;
      rx_ch_bit   <= 1'b0;
    end else begin
      rx_ch_valid <= rx_take;
      rx_ch_id    <= rx_take ? lane_cur[RXL].chan : '0;
      rx_ch_bit   <= rx_take && (lane_cur[RXL].swap ? line_tx_in : line_rx_in);
    end
  end

  // Transmit drive: launch for the entry of the period that starts at this edge
  logic tx_go;
  assign tx_go = lane_nact[TXL] && (lane_nxt[TXL].chan != '0);

  always_ff @(posedge clk_tx) begin
    if (rst) begin
      line_tx_out <= 1'b0;
      line_tx_oe  <= 1'b0;
      line_rx_out <= 1'b0;
      line_rx_oe  <= 1'b0;
      tx_ch_take  <= 1'b0;
      tx_ch_id    <= '0;
    end else begin
      line_tx_oe  <= tx_go && !lane_nxt[TXL].swap;
      line_rx_oe  <= tx_go &&  lane_nxt[TXL].swap;
      line_tx_out <= tx_go && !lane_nxt[TXL].swap && tx_ch_bit;
      line_rx_out <= tx_go &&  lane_nxt[TXL].swap && tx_ch_bit;
      tx_ch_take  <= tx_go;
      tx_ch_id    <= tx_go ? lane_nxt[TXL].chan : '0;
    end
  end

  // R6
  one_pin_drive_chk: assert property (@(posedge clk_tx) disable iff (rst)
    !(line_tx_oe && line_rx_oe));

  // R7
  tx_take_match_chk: assert property (@(posedge clk_tx) disable iff (rst)
    (line_tx_oe || line_rx_oe) == (tx_ch_take && tx_ch_id != '0));

  // R7
  rx_chan_nonzero_chk: assert property (@(posedge clk_rx) disable iff (rst)
    rx_ch_valid |-> (rx_ch_id != '0));

  // R4
  tx_idle_quiet_chk: assert property (@(posedge clk_tx) disable iff (rst)
    !lane_act[TXL] |-> (!line_tx_oe && !line_rx_oe && !tx_ch_take));

endmodule

// File: tb/sim_tdm_slot_router.sv
module sim_tdm_slot_router;

  localparam int DEPTH = 16;

  logic        clk_rx = 1'b0, clk_tx = 1'b0, rst = 1'b1;
  logic        rx_sync = 0, tx_sync = 0;
  logic        rx_wr_en = 0, tx_wr_en = 0;
  logic [3:0]  rx_wr_addr = 0, tx_wr_addr = 0;
  logic [15:0] rx_wr_data = 0, tx_wr_data = 0;
  logic [7:0]  strb_en = 8'hFF;
  logic        line_rx_in = 0, line_tx_in = 0, tx_ch_bit = 0;
  logic        line_tx_out, line_tx_oe, line_rx_out, line_rx_oe;
  logic        rx_ch_valid, rx_ch_bit, tx_ch_take;
  logic [2:0]  rx_ch_id, tx_ch_id;
  logic [7:0]  strb;

  always #4 clk_rx = ~clk_rx;                         // 125 MHz
  initial begin #3; forever #4 clk_tx = ~clk_tx; end  // same rate, shifted

  tdm_slot_router #(.DEPTH(DEPTH)) u0 (.*);

  int    checks = 0, errors = 0;
  string scen = "reset";

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s]: got %0h expected %0h", tag, scen, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit last, input bit byt, input int cnt,
                                     input int ch, input bit swp, input logic [3:0] s,
                                     input bit rsv);
    return {last, byt, 4'(cnt), 3'(ch), rsv, swp, rsv, s};
  endfunction

  function automatic int slen(input logic [15:0] e);
    return e[14] ? (int'(e[13:10]) + 1) * 8 : int'(e[13:10]) + 1;
  endfunction

  // ---------------- reference model ----------------
  logic [15:0] mrx [DEPTH];
  logic [15:0] mtx [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) begin mrx[i] = 0; mtx[i] = 0; end

  bit m_ra, m_ta;
  int m_ri, m_rp, m_ti, m_tp;
  logic       x_rv, x_rb, x_take, x_toe, x_roe, x_tout, x_rout;
  logic [2:0] x_rch, x_tch;
  logic [3:0] x_rs, x_ts;

  always @(posedge clk_rx) begin
    logic [15:0] e;
    bit old;
    if (rst) begin
      m_ra = 0; m_ri = 0; m_rp = 0;
      x_rv = 0; x_rch = 0; x_rb = 0; x_rs = 0;
    end else begin
      old = m_ra;
      e = mrx[m_ri];
      if (m_ra && e[9:7] != 0) begin
        x_rv = 1; x_rch = e[9:7]; x_rb = e[5] ? line_tx_in : line_rx_in;
      end else begin
        x_rv = 0; x_rch = 0; x_rb = 0;
      end
      if (rx_sync) begin m_ra = 1; m_ri = 0; m_rp = 0; end
      else if (m_ra) begin
        if (m_rp == slen(e) - 1) begin
          m_rp = 0;
          if (e[15]) m_ra = 0; else m_ri = (m_ri + 1) % DEPTH;
        end else m_rp++;
      end
      x_rs = m_ra ? (mrx[m_ri][3:0] & strb_en[3:0]) : 4'h0;
      if (rx_wr_en && !old) mrx[rx_wr_addr] = rx_wr_data;
    end
  end

  always @(posedge clk_tx) begin
    logic [15:0] e, n;
    bit old;
    if (rst) begin
      m_ta = 0; m_ti = 0; m_tp = 0;
      x_take = 0; x_tch = 0; x_toe = 0; x_roe = 0; x_tout = 0; x_rout = 0; x_ts = 0;
    end else begin
      old = m_ta;
      e = mtx[m_ti];
      if (tx_sync) begin m_ta = 1; m_ti = 0; m_tp = 0; end
      else if (m_ta) begin
        if (m_tp == slen(e) - 1) begin
          m_tp = 0;
          if (e[15]) m_ta = 0; else m_ti = (m_ti + 1) % DEPTH;
        end else m_tp++;
      end
      n = mtx[m_ti];
      if (m_ta && n[9:7] != 0) begin
        x_take = 1; x_tch = n[9:7]; x_toe = !n[5]; x_roe = n[5];
        x_tout = !n[5] && tx_ch_bit; x_rout = n[5] && tx_ch_bit;
      end else begin
        x_take = 0; x_tch = 0; x_toe = 0; x_roe = 0; x_tout = 0; x_rout = 0;
      end
      x_ts = m_ta ? (n[3:0] & strb_en[7:4]) : 4'h0;
      if (tx_wr_en && !old) mtx[tx_wr_addr] = tx_wr_data;
    end
  end

  // ---------------- per-edge comparison and monitors ----------------
  int   vcnt = 0, f0 = 0, f4 = 0;
  logic p0 = 0, p4 = 0;

  always @(negedge clk_rx) if (!rst) begin
    chk("R7 rx valid", 16'(rx_ch_valid), 16'(x_rv));
    chk("R7 rx channel", 16'(rx_ch_id), 16'(x_rch));
    chk("R5 rx bit", 16'(rx_ch_bit), 16'(x_rb));
    chk("R8 R9 R10 rx strobes", 16'(strb[3:0]), 16'(x_rs));
    vcnt += int'(rx_ch_valid);
    if (p0 && !strb[0]) f0++;
    p0 = strb[0];
  end

  always @(negedge clk_tx) if (!rst) begin
    chk("R6 tx pin enable", 16'(line_tx_oe), 16'(x_toe));
    chk("R6 rx pin enable", 16'(line_rx_oe), 16'(x_roe));
    chk("R6 tx pin data", 16'(line_tx_out), 16'(x_tout));
    chk("R6 rx pin data", 16'(line_rx_out), 16'(x_rout));
    chk("R7 tx take", 16'({tx_ch_take, tx_ch_id}), 16'({x_take, x_tch}));
    chk("R8 R9 R10 tx strobes", 16'(strb[7:4]), 16'(x_ts));
    if (p4 && !strb[4]) f4++;
    p4 = strb[4];
  end

  // Line and channel data change away from the edges that sample them
  always @(negedge clk_rx) begin
    line_rx_in <= 1'($urandom);
    line_tx_in <= 1'($urandom);
  end
  always @(negedge clk_tx) tx_ch_bit <= 1'($urandom);

  // ---------------- stimulus tasks ----------------
  task automatic wr_rx(input int a, input logic [15:0] d);
    @(negedge clk_rx); rx_wr_en = 1; rx_wr_addr = 4'(a); rx_wr_data = d;
    @(negedge clk_rx); rx_wr_en = 0;
  endtask

  task automatic wr_tx(input int a, input logic [15:0] d);
    @(negedge clk_tx); tx_wr_en = 1; tx_wr_addr = 4'(a); tx_wr_data = d;
    @(negedge clk_tx); tx_wr_en = 0;
  endtask

  task automatic sync_both();
    @(negedge clk_rx); rx_sync = 1;
    @(negedge clk_tx); tx_sync = 1;
    @(negedge clk_rx); rx_sync = 0;
    @(negedge clk_tx); tx_sync = 0;
  endtask

  task automatic idle_rx(input int n);
    repeat (n) @(negedge clk_rx);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    idle_rx(4);
    rst = 0;
    idle_rx(1);
    scen = "R1";
    chk("R1 strobes after reset", 16'(strb), 16'h0);
    chk("R1 enables after reset", 16'({line_tx_oe, line_rx_oe}), 16'h0);
    chk("R1 channel flags after reset", 16'({rx_ch_valid, tx_ch_take}), 16'h0);

    // Tables: bit and byte slots, swapped slots, a silent slot, reserved bits set
    wr_rx(0, mk(0, 0, 2, 1, 0, 4'b0001, 0));
    wr_rx(1, mk(0, 1, 0, 2, 1, 4'b0011, 0));
    wr_rx(2, mk(0, 0, 1, 0, 0, 4'b0100, 0));
    wr_rx(3, mk(1, 0, 3, 3, 0, 4'b1000, 1));
    wr_tx(0, mk(0, 0, 3, 4, 0, 4'b0001, 0));
    wr_tx(1, mk(0, 0, 5, 5, 1, 4'b0001, 0));
    wr_tx(2, mk(0, 1, 1, 0, 1, 4'b0010, 1));
    wr_tx(3, mk(1, 0, 0, 6, 0, 4'b1001, 0));

    scen = "R2 R5 R6 R8 R9 R11 full pass";
    vcnt = 0; f0 = 0; f4 = 0;
    sync_both();
    idle_rx(40);
    chk("R2 receive bits forwarded", 16'(vcnt), 16'd15);
    chk("R9 strobe 1 negations", 16'(f0), 16'd1);
    chk("R9 strobe 5 negations", 16'(f4), 16'd2);
    scen = "R4 idle";
    chk("R4 strobes idle", 16'(strb), 16'h0);
    chk("R4 enables idle", 16'({line_tx_oe, line_rx_oe}), 16'h0);
    chk("R4 nothing forwarded", 16'({rx_ch_valid, tx_ch_take}), 16'h0);

    scen = "R3 restart mid-pass";
    sync_both();
    idle_rx(5);
    sync_both();
    vcnt = 0;
    idle_rx(40);
    chk("R3 bits after restart", 16'(vcnt), 16'd15);

    scen = "R10 strobe enables";
    strb_en = 8'h5A;
    sync_both();
    idle_rx(40);
    strb_en = 8'hFF;

    scen = "R12 write during pass";
    sync_both();
    idle_rx(2);
    wr_rx(3, mk(1, 0, 3, 0, 0, 4'b0000, 0));
    wr_tx(0, mk(1, 0, 0, 0, 0, 4'b0000, 0));
    idle_rx(40);
    vcnt = 0; f4 = 0;
    sync_both();
    idle_rx(40);
    chk("R12 receive table unchanged", 16'(vcnt), 16'd15);
    chk("R12 transmit table unchanged", 16'(f4), 16'd2);

    scen = "R12 write while idle";
    wr_rx(3, mk(1, 0, 3, 0, 0, 4'b0000, 0));
    vcnt = 0;
    sync_both();
    idle_rx(40);
    chk("R12 idle write applied", 16'(vcnt), 16'd11);

    idle_rx(4);
    finish_run();
  end

endmodule